// File: doc/BRIEF.md
# Four-Byte Serial Instruction Target

This block is the target end of an in-system programming link. A host shifts bytes in on `ser_din`, timed by its serial clock `ser_clk`, and reads one byte back on `ser_dout` for every byte it sends. The block groups every four bytes into one instruction. It hands the opcode, the two address bytes and the data byte to a downstream command handler with a single-cycle `cmd_valid` strobe. The link is open only while `tgt_rst` is held low. Driving `tgt_rst` high closes the session and puts the byte framing back to its start.

The serial lines are sampled against the faster system clock `clk` through two-flop synchronizers. Edges of the serial clock are found by comparing the synchronized level with its value one cycle earlier. Every byte slot returns the byte received just before it, so the host can confirm that framing is aligned. The one exception is the fourth slot of a read instruction in an open session, which returns the byte on `rd_data`. Until an enable instruction with the correct sync byte has been framed, no instruction reaches the command handler.

The controller has four states, and the transitions between them are as follows:
- `ST_OFF` is the session-closed state. It moves to `ST_HUNT` when `tgt_rst` goes low.
- `ST_HUNT` waits for an enable instruction. It moves to `ST_LIVE` when a framed instruction carries the enable opcode and the sync byte.
- `ST_LIVE` is the open session. It moves to `ST_ISSUE` when it frames any instruction whose opcode is not the enable opcode.
- `ST_ISSUE` pulses `cmd_valid` and returns to `ST_LIVE` on the next cycle.
- From any state, `tgt_rst` high leads to `ST_OFF`.

Top module: `isp_serial_slave`

## Requirements
- R1: `ser_din` is sampled on each rising edge of `ser_clk`, most significant bit first. Each group of four bytes is one instruction. Bytes 0 to 3 appear on `cmd_op`, `cmd_addr_hi`, `cmd_addr_lo` and `cmd_data`.
- R2: `ser_dout` changes only after a falling edge of `ser_clk`, or when the session is closed.
- R3: Each byte slot shifts out the byte received in the slot before it. The first slot after the session opens returns 0x00. In particular, the sync byte 0x53 is returned during the third byte of the enable instruction.
- R4: The enable instruction has 0xAC as byte 0 and 0x53 as byte 1. Before it has been framed, no instruction raises `cmd_valid`. An instruction with opcode 0xAC never raises `cmd_valid`.
- R5: An enable instruction whose byte 1 is not 0x53 does not open the session. All four of its bytes are still consumed, so the next instruction is framed correctly.
- R6: In an open session, an instruction with opcode 0x20 (read) returns `rd_data` during its fourth slot. `rd_data` is sampled as that slot begins. Before the session is enabled, the same instruction only gets the echo.
- R7: While `tgt_rst` is high, `ser_dout` is 0 and `cmd_valid` stays low. Raising `tgt_rst` cancels the enabled state, so a later command is ignored until a new enable instruction arrives.
- R8: A `tgt_rst` pulse in the middle of an instruction restarts framing at byte 0 of the next instruction.
- R9: `cmd_valid` is high for exactly one `clk` cycle for each accepted instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| tgt_rst | input | 1 | Session control pin, low keeps the link open |
| ser_clk | input | 1 | Serial clock from the host |
| ser_din | input | 1 | Serial data from the host |
| ser_dout | output | 1 | Serial data to the host |
| cmd_valid | output | 1 | One-cycle strobe for an accepted instruction |
| cmd_op | output | 8 | Instruction byte 0 (opcode) |
| cmd_addr_hi | output | 8 | Instruction byte 1 |
| cmd_addr_lo | output | 8 | Instruction byte 2 |
| cmd_data | output | 8 | Instruction byte 3 |
| rd_data | input | 8 | Read-back byte from the command handler |

## Verification
The hardest case to reach from the ports is a session reset that lands in the middle of an instruction. After it, the framing counters must restart and the enabled state must be gone, while the host's own byte history is discarded. The bench sends two bytes of a write, pulses `tgt_rst`, and checks that `ser_dout` is held at zero during the pulse. It then sends a write that must be ignored, and finally an enable followed by a write that must be accepted. The read slot is also delicate, because `rd_data` depends on address bytes framed only a few cycles before the slot begins. The bench therefore drives `rd_data` as a function of the block's address outputs and predicts that value for each read.

// File: rtl/isp_pkg.sv
package isp_pkg;
    typedef enum logic [1:0] {
        ST_OFF,
        ST_HUNT,
        ST_LIVE,
        ST_ISSUE
    } isp_state_e;
endpackage

// File: rtl/isp_sync.sv
module isp_sync #(
    parameter int           W    = 3,
    parameter logic [W-1:0] INIT = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Two flops per line; each line is independent.
    for (genvar i = 0; i < W; i++) begin : g_line
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta[i] <= INIT[i];
                q[i]    <= INIT[i];
            end else begin
                meta[i] <= d[i];
                q[i]    <= meta[i];
            end
        end
    end
endmodule

// File: rtl/isp_shifter.sv
module isp_shifter #(
    parameter int BW     = 8,
    parameter int NBYTES = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         sess_off,
    input  logic                         rise,
    input  logic                         fall,
    input  logic                         din,
    input  logic                         rd_sel,
    input  logic [BW-1:0]                rd_data,
    output logic                         dout,
    output logic [NBYTES-1:0][BW-1:0]    frame_q,
    output logic                         frame_done
);
    localparam int BCW  = $clog2(BW);
    localparam int IDXW = $clog2(NBYTES);
    localparam logic [BCW-1:0]  LAST_BIT  = BCW'(BW - 1);
    localparam logic [IDXW-1:0] LAST_BYTE = IDXW'(NBYTES - 1);

    logic [BW-2:0]   rx_sh;
    logic [BW-1:0]   tx_sh;
    logic [BW-1:0]   last_rx;
    logic [BCW-1:0]  bit_cnt;
    logic [IDXW-1:0] byte_idx;
    logic [BW-1:0]   rx_byte;
    logic [BW-1:0]   tx_load;

    assign rx_byte = {rx_sh, din};
    // Final slot of a read returns memory data; every other slot echoes.
    assign tx_load = (rd_sel && byte_idx == LAST_BYTE) ? rd_data : last_rx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_sh      <= '0;
            tx_sh      <= '0;
            last_rx    <= '0;
            bit_cnt    <= '0;
            byte_idx   <= '0;
            dout       <= 1'b0;
            frame_q    <= '0;
            frame_done <= 1'b0;
        end else if (sess_off) begin
            rx_sh      <= '0;
            tx_sh      <= '0;
            last_rx    <= '0;
            bit_cnt    <= '0;
            byte_idx   <= '0;
            dout       <= 1'b0;
            frame_done <= 1'b0;
        end else begin
            frame_done <= 1'b0;
            if (rise) begin
                rx_sh   <= rx_byte[BW-2:0];
                bit_cnt <= (bit_cnt == LAST_BIT) ? '0 : bit_cnt + 1'b1;
                if (bit_cnt == LAST_BIT) begin
                    frame_q[byte_idx] <= rx_byte;
                    last_rx           <= rx_byte;
                    byte_idx          <= (byte_idx == LAST_BYTE) ? '0 : byte_idx + 1'b1;
                    frame_done        <= (byte_idx == LAST_BYTE);
                end
            end
            if (fall) begin
                if (bit_cnt == '0) begin
                    dout  <= tx_load[BW-1];
                    tx_sh <= {tx_load[BW-2:0], 1'b0};
                end else begin
                    dout  <= tx_sh[BW-1];
                    tx_sh <= {tx_sh[BW-2:0], 1'b0};
                end
            end
        end
    end

    assert_dout_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dout) |-> ($past(fall) || $past(sess_off)));

    assert_off_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sess_off |=> (bit_cnt == '0 && byte_idx == '0 && !dout));

    assert_frame_boundary_R1: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> (byte_idx == '0 && bit_cnt == '0));
endmodule

// File: rtl/isp_frame_fsm.sv
module isp_frame_fsm
    import isp_pkg::*;
#(
    parameter int          BW        = 8,
    parameter logic [BW-1:0] ENABLE_OP = 8'hAC,
    parameter logic [BW-1:0] SYNC_BYTE = 8'h53
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sess_off,
    input  logic          frame_done,
    input  logic [BW-1:0] op_byte,
    input  logic [BW-1:0] second_byte,
    output logic          live,
    output logic          cmd_valid
);
    isp_state_e state, state_nx;
    logic is_enable_op;

    assign is_enable_op = (op_byte == ENABLE_OP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OFF:   if (!sess_off) state_nx = ST_HUNT;
            ST_HUNT:  if (sess_off) state_nx = ST_OFF;
                      else if (frame_done && is_enable_op && second_byte == SYNC_BYTE)
                          state_nx = ST_LIVE;
            ST_LIVE:  if (sess_off) state_nx = ST_OFF;
                      else if (frame_done && !is_enable_op) state_nx = ST_ISSUE;
            ST_ISSUE: if (sess_off) state_nx = ST_OFF;
                      else state_nx = ST_LIVE;
            default:  state_nx = ST_OFF;
        endcase
    end

    always_comb begin
        live      = (state == ST_LIVE) || (state == ST_ISSUE);
        cmd_valid = (state == ST_ISSUE);
    end

    assert_single_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);
endmodule

// File: rtl/isp_serial_slave.sv
module isp_serial_slave #(
    parameter int            BW        = 8,
    parameter logic [BW-1:0] ENABLE_OP = 8'hAC,
    parameter logic [BW-1:0] SYNC_BYTE = 8'h53,
    parameter logic [BW-1:0] READ_OP   = 8'h20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tgt_rst,
    input  logic          ser_clk,
    input  logic          ser_din,
    output logic          ser_dout,
    output logic          cmd_valid,
    output logic [BW-1:0] cmd_op,
    output logic [BW-1:0] cmd_addr_hi,
    output logic [BW-1:0] cmd_addr_lo,
    output logic [BW-1:0] cmd_data,
    input  logic [BW-1:0] rd_data
);
    localparam int NBYTES = 4;

    logic [2:0] sync_q;
    logic sess_off, sclk_s, din_s, sclk_d;
    logic rise, fall, live, rd_sel, frame_done;
    logic [NBYTES-1:0][BW-1:0] frame_q;

    isp_sync #(.W(3), .INIT(3'b100)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({tgt_rst, ser_clk, ser_din}), .q(sync_q)
    );
    assign {sess_off, sclk_s, din_s} = sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_d <= 1'b0;
        else        sclk_d <= sclk_s;
    end
    assign rise = sclk_s & ~sclk_d;
    assign fall = ~sclk_s & sclk_d;

    assign rd_sel = live && (frame_q[0] == READ_OP);

    isp_shifter #(.BW(BW), .NBYTES(NBYTES)) u_shift (
        .clk(clk), .rst_n(rst_n), .sess_off(sess_off),
        .rise(rise), .fall(fall), .din(din_s),
        .rd_sel(rd_sel), .rd_data(rd_data),
        .dout(ser_dout), .frame_q(frame_q), .frame_done(frame_done)
    );

    isp_frame_fsm #(.BW(BW), .ENABLE_OP(ENABLE_OP), .SYNC_BYTE(SYNC_BYTE)) u_fsm (
        .clk(clk), .rst_n(rst_n), .sess_off(sess_off),
        .frame_done(frame_done), .op_byte(frame_q[0]), .second_byte(frame_q[1]),
        .live(live), .cmd_valid(cmd_valid)
    );

    assign cmd_op      = frame_q[0];
    assign cmd_addr_hi = frame_q[1];
    assign cmd_addr_lo = frame_q[2];
    assign cmd_data    = frame_q[3];

    assert_no_enable_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_op != ENABLE_OP));
endmodule

// File: tb/sim_isp_serial_slave.sv
module sim_isp_serial_slave;
    localparam int HALF = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tgt_rst = 1'b1;
    logic ser_clk = 1'b0;
    logic ser_din = 1'b0;
    logic ser_dout, cmd_valid;
    logic [7:0] cmd_op, cmd_addr_hi, cmd_addr_lo, cmd_data, rd_data;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #4 clk = ~clk;

    function automatic logic [7:0] mem_model(input logic [7:0] a, input logic [7:0] b);
        return a ^ {b[3:0], b[7:4]} ^ 8'h5A;
    endfunction

    assign rd_data = mem_model(cmd_addr_hi, cmd_addr_lo);

    isp_serial_slave u0 (
        .clk(clk), .rst_n(rst_n), .tgt_rst(tgt_rst),
        .ser_clk(ser_clk), .ser_din(ser_din), .ser_dout(ser_dout),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr_hi(cmd_addr_hi),
        .cmd_addr_lo(cmd_addr_lo), .cmd_data(cmd_data), .rd_data(rd_data)
    );

    // Scoreboard queues
    logic [7:0]  exp_q[$];
    logic [7:0]  got_q[$];
    string       tag_q[$];
    logic [31:0] cmd_q[$];

    // Bench-side model
    logic [7:0] last_tx = 8'h00;
    bit         en_model = 0;

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic xfer(input logic [7:0] tx, input logic [7:0] exp, input string tag);
        logic [7:0] got;
        for (int i = 7; i >= 0; i--) begin
            ser_din = tx[i];
            repeat (HALF) @(negedge clk);
            got[i] = ser_dout;
            ser_clk = 1'b1;
            repeat (HALF) @(negedge clk);
            ser_clk = 1'b0;
        end
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        got_q.push_back(got);
    endtask

    task automatic instr(input logic [7:0] b0, input logic [7:0] b1,
                         input logic [7:0] b2, input logic [7:0] b3);
        logic [7:0] e3;
        bit is_rd;
        is_rd = en_model && (b0 == 8'h20);
        e3 = is_rd ? mem_model(b1, b2) : b2;
        if (en_model && b0 != 8'hAC) cmd_q.push_back({b0, b1, b2, b3});
        xfer(b0, last_tx, "R3");
        xfer(b1, b0, "R1");
        xfer(b2, b1, "R3");
        xfer(b3, e3, is_rd ? "R6" : "R3");
        last_tx = b3;
        if (!en_model && b0 == 8'hAC && b1 == 8'h53) en_model = 1;
        repeat (20) @(negedge clk);
    endtask

    task automatic sess_pulse();
        tgt_rst = 1'b1;
        repeat (10) @(negedge clk);
        check("R7 dout low in reset", {31'b0, ser_dout}, 32'd0);
        check("R7 no strobe in reset", {31'b0, cmd_valid}, 32'd0);
        tgt_rst = 1'b0;
        repeat (10) @(negedge clk);
        last_tx = 8'h00;
        en_model = 0;
    endtask

    // Monitor: byte scoreboard
    always @(negedge clk) begin
        if (got_q.size() > 0) begin
            logic [7:0] g, e;
            string t;
            g = got_q.pop_front();
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, {24'b0, g}, {24'b0, e});
        end
    end

    // Monitor: command scoreboard
    always @(negedge clk) begin
        if (rst_n && cmd_valid) begin
            if (cmd_q.size() == 0) begin
                check("R4 unexpected cmd", {cmd_op, cmd_addr_hi, cmd_addr_lo, cmd_data}, 32'hFFFF_FFFF);
            end else begin
                check("R1 R9 cmd fields", {cmd_op, cmd_addr_hi, cmd_addr_lo, cmd_data}, cmd_q.pop_front());
            end
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R7 reset dout", {31'b0, ser_dout}, 32'd0);
        check("R7 reset strobe", {31'b0, cmd_valid}, 32'd0);
        tgt_rst = 1'b0;
        repeat (10) @(negedge clk);

        // R4 R6: read and write before enable are ignored
        instr(8'h20, 8'h01, 8'h02, 8'h00);
        instr(8'h40, 8'h11, 8'h22, 8'h33);
        // R5: wrong sync byte does not enable, framing kept
        instr(8'hAC, 8'h35, 8'h00, 8'h00);
        instr(8'h40, 8'h12, 8'h34, 8'h56);
        // R3 R4: proper enable, 0x53 echoed in third slot
        instr(8'hAC, 8'h53, 8'h00, 8'h00);
        // R1 R9: commands accepted
        instr(8'h40, 8'hA5, 8'h3C, 8'h99);
        instr(8'hC0, 8'h00, 8'hFF, 8'h01);
        // R6: reads return rd_data in fourth slot
        instr(8'h20, 8'h12, 8'h34, 8'h00);
        instr(8'h20, 8'hF0, 8'h0F, 8'h00);
        // R4: a repeat enable issues no command
        instr(8'hAC, 8'h53, 8'h77, 8'h00);
        // R8: session reset in mid-instruction
        xfer(8'h40, last_tx, "R8");
        xfer(8'h01, 8'h40, "R8");
        sess_pulse();
        // R7: session closed, write ignored until new enable
        instr(8'h40, 8'h02, 8'h03, 8'h04);
        instr(8'hAC, 8'h53, 8'h00, 8'h00);
        instr(8'h48, 8'h5A, 8'hC3, 8'h7E);
        instr(8'h20, 8'h81, 8'h18, 8'h00);

        repeat (30) @(negedge clk);
        check("R9 pending cmds", cmd_q.size(), 0);
        check("R1 pending bytes", got_q.size(), 0);
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule